// File: doc/BRIEF.md
# Processor Supervisor: Reset Hold and Watchdog

This block watches over a processor and drives one reset line to it. Reset is raised whenever the block itself is reset (power-up) or the supply-good indication is low. Once conditions are good again, reset stays active for a fixed stabilisation time so that the supply and clock can settle before code runs. The supply-good input is a synchronous logic level that stands in for an analog comparator placed elsewhere.

After reset is released, a watchdog counts clock cycles. The host restarts it with a one-cycle strobe. If no strobe arrives within the selected interval, the block raises reset again for the same stabilisation time. The 2-bit interval select comes from a non-volatile configuration register outside the block, so the block's own reset does not clear it. Three codes choose preset cycle counts and the fourth code turns the watchdog off. A build parameter sets the output polarity to active-low or active-high.

Top module: `cpu_supervisor`

## Requirements
- R1: While `rst` is high, reset is active. After `rst` falls with `pwr_good` high, reset stays active for exactly HOLD_CYCLES rising edges and is then released.
- R2: If `pwr_good` is low at a rising edge, reset is active after that edge and stays active while `pwr_good` stays low.
- R3: Once `pwr_good` is high again, reset is released after exactly HOLD_CYCLES more edges. A drop of `pwr_good` during the hold period restarts the full hold period.
- R4: If no restart strobe arrives, reset is raised exactly WD_T0, WD_T1 or WD_T2 edges after release, for `wd_sel` codes 00, 01 and 10 respectively.
- R5: A restart strobe (`kick` high for one edge while reset is inactive) clears the watchdog. Any run of fewer than the selected interval of edges without a strobe never trips it. After the last strobe, reset is raised exactly the interval later.
- R6: With `wd_sel` = 11 the watchdog never trips and its count is held at zero. Selecting a preset code afterwards times out one full interval later.
- R7: A watchdog reset is held for exactly HOLD_CYCLES edges, the same as a power-on hold. The watchdog count is zero while reset is active, so it restarts from zero at release.
- R8: A `kick` seen while reset is active is ignored. It neither shortens the hold period nor preloads the watchdog.
- R9: With ACTIVE_LOW = 1, `rst_out` is 0 when reset is active and 1 when inactive. With ACTIVE_LOW = 0 the levels are inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset of the block |
| pwr_good | input | 1 | Synchronous supply-good level, high when the supply is good |
| kick | input | 1 | Watchdog restart strobe, one cycle per restart |
| wd_sel | input | 2 | Watchdog interval: 00/01/10 are presets, 11 turns the watchdog off |
| rst_out | output | 1 | Reset to the processor, polarity set by ACTIVE_LOW |

## Verification
The bench uses short intervals so that every `wd_sel` code can be swept in full.

For each preset code it measures:
- the edge count from release to trip, which separates the three intervals from each other and from an off-by-one;
- the hold length after a watchdog trip, a power-on reset and a supply drop, which shows the hold counter is shared and restarts correctly after a dip;
- strobes spaced one edge short of the interval, which confirm that restarts work right at the boundary.

Strobes held high through a hold period, followed by a full-length timeout, show that the ignored strobe preloads nothing. Two instances built with opposite polarity run side by side, and the bench compares them on every cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        SUP_HOLD = 1'b0,
        SUP_RUN  = 1'b1
    } sup_state_e;

    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction

endpackage

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 16,
    localparam int unsigned HW = sup_pkg::cnt_width(HOLD_CYCLES)
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic done
);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

    logic [HW-1:0] cnt;

    assign done = count_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt <= '0;
        end else if (done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int unsigned WD_T0 = 1000,
    parameter int unsigned WD_T1 = 4000,
    parameter int unsigned WD_T2 = 16000,
    localparam int unsigned WD_W = cnt_width(max3(WD_T0, WD_T1, WD_T2))
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            kick,
    input  logic [1:0]      wd_sel,
    output logic            expire,
    output logic [WD_W-1:0] count
);
    localparam logic [WD_W-1:0] LIM0 = WD_W'(WD_T0 - 1);
    localparam logic [WD_W-1:0] LIM1 = WD_W'(WD_T1 - 1);
    localparam logic [WD_W-1:0] LIM2 = WD_W'(WD_T2 - 1);

    wd_sel_e         sel;
    logic            off;
    logic [WD_W-1:0] lim;
    logic [WD_W-1:0] cnt;

    assign sel = wd_sel_e'(wd_sel);

    always_comb begin
        off = 1'b0;
        lim = LIM0;
        case (sel)
            WD_SHORT: lim = LIM0;
            WD_MID:   lim = LIM1;
            WD_LONG:  lim = LIM2;
            default:  off = 1'b1;
        endcase
    end

    assign expire = run && !kick && !off && (cnt >= lim);
    assign count  = cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (kick || off || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic hold_done,
    input  logic wd_expire,
    output logic holding
);
    sup_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            SUP_HOLD: if (hold_done) state_nx = SUP_RUN;
            SUP_RUN:  if (!pwr_good || wd_expire) state_nx = SUP_HOLD;
            default:  state_nx = SUP_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SUP_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    assign holding = (state == SUP_HOLD);
endmodule

// File: rtl/cpu_supervisor.sv
module cpu_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16,
    parameter int unsigned WD_T0 = 1000,
    parameter int unsigned WD_T1 = 4000,
    parameter int unsigned WD_T2 = 16000,
    parameter bit          ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       kick,
    input  logic [1:0] wd_sel,
    output logic       rst_out
);
    localparam int unsigned WD_W = cnt_width(max3(WD_T0, WD_T1, WD_T2));

    logic            rst_act;
    logic            hold_done;
    logic            wd_expire;
    logic [WD_W-1:0] wd_cnt;

    sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .count_en (rst_act && pwr_good),
        .done     (hold_done)
    );

    sup_wdog #(.WD_T0(WD_T0), .WD_T1(WD_T1), .WD_T2(WD_T2)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .run    (!rst_act),
        .kick   (kick),
        .wd_sel (wd_sel),
        .expire (wd_expire),
        .count  (wd_cnt)
    );

    sup_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pwr_good  (pwr_good),
        .hold_done (hold_done),
        .wd_expire (wd_expire),
        .holding   (rst_act)
    );

    generate
        if (ACTIVE_LOW) begin : g_low
            assign rst_out = ~rst_act;
        end else begin : g_high
            assign rst_out = rst_act;
        end
    endgenerate
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int unsigned WD_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            pwr_good,
    input logic            kick,
    input logic [1:0]      wd_sel,
    input logic            rst_act,
    input logic            wd_expire,
    input logic [WD_W-1:0] wd_cnt
);
    assert_hold_after_por_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rst_act);

    assert_supply_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> rst_act);

    assert_trip_raises_reset_R4: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> rst_act);

    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (kick && !rst_act) |=> (wd_cnt == '0));

    assert_off_holds_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (wd_sel == 2'b11) |=> (wd_cnt == '0));

    assert_count_idle_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
        rst_act |=> (wd_cnt == '0));

    assert_no_trip_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        rst_act |-> !wd_expire);
endmodule

bind cpu_supervisor sup_checker #(.WD_W(WD_W)) u_sup_checker (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .kick      (kick),
    .wd_sel    (wd_sel),
    .rst_act   (rst_act),
    .wd_expire (wd_expire),
    .wd_cnt    (wd_cnt)
);

// File: tb/cpu_supervisor_bench.sv
module cpu_supervisor_bench;
    localparam int HOLD = 6;
    localparam int T0 = 5;
    localparam int T1 = 9;
    localparam int T2 = 14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b1;
    logic       kick = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       rst_lo;
    logic       rst_hi;

    int  n_chk = 0;
    int  n_bad = 0;
    int  pol_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    cpu_supervisor #(.HOLD_CYCLES(HOLD), .WD_T0(T0), .WD_T1(T1), .WD_T2(T2),
                     .ACTIVE_LOW(1'b1)) u_cpu_supervisor (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .kick(kick),
        .wd_sel(wd_sel), .rst_out(rst_lo));

    cpu_supervisor #(.HOLD_CYCLES(HOLD), .WD_T0(T0), .WD_T1(T1), .WD_T2(T2),
                     .ACTIVE_LOW(1'b0)) u_cpu_supervisor_hi (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .kick(kick),
        .wd_sel(wd_sel), .rst_out(rst_hi));

    // R9: opposite polarity builds must always be complementary
    always @(negedge clk) if (rst_hi !== ~rst_lo) pol_bad++;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic int act();
        return (rst_lo == 1'b0) ? 1 : 0;
    endfunction

    function automatic int lim(input int s);
        case (s)
            0: return T0;
            1: return T1;
            default: return T2;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic meas_on(output int n);
        n = 0;
        while (act() == 1 && n < 500) begin tick(); n++; end
    endtask

    task automatic meas_off(output int n);
        n = 0;
        while (act() == 0 && n < 500) begin tick(); n++; end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        int n;
        int trips;
        #2;
        repeat (3) tick();
        chk("R1 active during rst", act(), 1);
        chk("R9 active-low level when active", int'(rst_lo), 0);
        chk("R9 active-high level when active", int'(rst_hi), 1);
        rst = 1'b0;
        meas_on(n);
        chk("R1 hold after por", n, HOLD);
        chk("R9 active-low level when inactive", int'(rst_lo), 1);
        chk("R9 active-high level when inactive", int'(rst_hi), 0);

        for (int s = 0; s < 3; s++) begin
            wd_sel = 2'(s);
            pwr_good = 1'b0;
            tick();
            chk("R2 reset on supply drop", act(), 1);
            trips = 0;
            repeat (4) begin tick(); if (act() == 0) trips++; end
            chk("R2 held while supply low", trips, 0);
            pwr_good = 1'b1;
            meas_on(n);
            chk("R3 hold after supply return", n, HOLD);
            meas_off(n);
            chk($sformatf("R4 timeout sel=%0d", s), n, lim(s));
            meas_on(n);
            chk("R7 hold after watchdog trip", n, HOLD);
            meas_off(n);
            chk("R7 count restarts from zero", n, lim(s));
            meas_on(n);
            trips = 0;
            repeat (4) begin
                kick = 1'b1; tick(); kick = 1'b0;
                if (act() == 1) trips++;
                repeat (lim(s) - 1) begin tick(); if (act() == 1) trips++; end
            end
            chk("R5 strobes at boundary never trip", trips, 0);
            kick = 1'b1; tick(); kick = 1'b0;
            meas_off(n);
            chk("R5 trip one interval after last strobe", n, lim(s));
            kick = 1'b1;
            meas_on(n);
            kick = 1'b0;
            chk("R8 strobes in hold keep hold length", n, HOLD);
            meas_off(n);
            chk("R8 strobes in hold preload nothing", n, lim(s));
        end

        pwr_good = 1'b0; tick(); pwr_good = 1'b1;
        repeat (3) tick();
        pwr_good = 1'b0; tick();
        chk("R3 dip in hold keeps reset", act(), 1);
        pwr_good = 1'b1;
        meas_on(n);
        chk("R3 dip restarts hold", n, HOLD);

        wd_sel = 2'b11;
        trips = 0;
        repeat (3 * T2) begin tick(); if (act() == 1) trips++; end
        chk("R6 disabled never trips", trips, 0);
        wd_sel = 2'b00;
        meas_off(n);
        chk("R6 re-enable times out one interval", n, T0);

        rst = 1'b1; tick();
        chk("R1 rst while running", act(), 1);
        rst = 1'b0;
        meas_on(n);
        chk("R1 hold after mid-run rst", n, HOLD);

        chk("R9 complementary outputs", pol_bad, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule